// File: doc/BRIEF.md
# Moore Serial 0-1-0 Pattern Detector

This block watches a one-bit serial stream and raises a single output flag for one step each time the last three accepted bits were 0, then 1, then 0. It is a four-state Moore machine. The flag comes from a register and depends only on the state, so it is free of glitches and ignores the input bit during the cycle in which it is shown. Matches may overlap: the final 0 of one match can serve as the first 0 of the next.

A step-enable input lets the machine run slower than the system clock while staying fully synchronous. On an edge where the enable is low, the state and the flag are both held. A typical use is a one-cycle enable pulse every third clock, which makes the detector advance at one third of the clock rate. Reset is synchronous and has priority over the enable.

Top module: `pd_serial_det`

## Requirements
- R1: When `rst` is high at a rising edge, the machine goes to its idle state (no bits matched) and `z_out` is 0 in the following cycle. Both stay that way for as long as `rst` is held high.
- R2: Reset acts whatever the value of `en`. An edge with `rst` high and `en` low still clears any partial match, so a later `1,0` cannot finish a pattern that began before the reset.
- R3: If the three most recent bits accepted on enabled edges since reset are 0, 1, 0 (oldest first), `z_out` is 1 in the cycle after the edge that accepted the last 0. Otherwise it is 0.
- R4: Matches overlap. The stream 0,1,0,1,0 gives two pulses. After a match, a further 0 leaves one 0 already counted.
- R5: Streams without the pattern never raise `z_out`. This covers runs of 1s from idle, runs of 0s, and 0,1,1, which discards the partial match.
- R6: `z_out` is a Moore output. It stays high for exactly one enabled step, and changing `x_in` while it is high has no effect until the next enabled edge.
- R7: On a rising edge with `en` low and `rst` low, the state and `z_out` are held and `x_in` is ignored.
- R8: With `en` pulsed for one clock out of every three, the detector advances once per pulse, and a match holds `z_out` high for three system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge system clock |
| rst | input | 1 | Synchronous active-high reset, priority over en |
| en | input | 1 | Step enable; low holds all state |
| x_in | input | 1 | Serial data bit, sampled on enabled edges |
| z_out | output | 1 | Registered match flag, high in the match state |

## Verification
Two events can fall on the same edge: a reset request and a step that would complete or extend a match. The bench also pairs a held enable with a pending match bit. It provokes these cases by building a partial 0,1 match and then asserting `rst` with `en` low and `x_in` at the completing value. After that it feeds the missing bit and judges that no pulse appears. It also holds `en` low while `x_in` toggles under a raised flag and judges that the flag keeps its value. A shift-of-three reference model is compared with `z_out` every cycle, over directed streams and over random streams with random enable gaps.

// File: rtl/pd_pkg.sv
package pd_pkg;

  localparam int unsigned PD_STATE_W = 2;

  typedef enum logic [PD_STATE_W-1:0] {
    PD_IDLE  = 2'd0,
    PD_SAW0  = 2'd1,
    PD_SAW01 = 2'd2,
    PD_HIT   = 2'd3
  } pd_state_e;

  // Next state of the 0-1-0 recogniser for one accepted bit.
  function automatic pd_state_e pd_advance(input pd_state_e cur, input logic bit_in);
    pd_state_e nxt;
    unique case (cur)
      PD_IDLE:  nxt = bit_in ? PD_IDLE  : PD_SAW0;
      PD_SAW0:  nxt = bit_in ? PD_SAW01 : PD_SAW0;
      PD_SAW01: nxt = bit_in ? PD_IDLE  : PD_HIT;
      PD_HIT:   nxt = bit_in ? PD_SAW01 : PD_SAW0;
      default:  nxt = PD_IDLE;
    endcase
    return nxt;
  endfunction

  // Moore output decode.
  function automatic logic pd_flag(input pd_state_e st);
    return (st == PD_HIT);
  endfunction

endpackage

// File: rtl/pd_next.sv
module pd_next
  import pd_pkg::*;
(
  input  pd_state_e cur_st,
  input  logic      bit_in,
  output pd_state_e nxt_st,
  output logic      nxt_flag
);

  always_comb begin
    nxt_st   = pd_advance(cur_st, bit_in);
    nxt_flag = pd_flag(nxt_st);
  end

endmodule

// File: rtl/pd_state_reg.sv
module pd_state_reg
  import pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      step,
  input  pd_state_e nxt_st,
  output pd_state_e cur_st
);

  always_ff @(posedge clk) begin
    if (rst)       cur_st <= PD_IDLE;
    else if (step) cur_st <= nxt_st;
  end

  // R1 / R2: reset wins regardless of enable
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (cur_st == PD_IDLE));

  // R7: no step, no state change
  a_r7_hold_state: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cur_st));

endmodule

// File: rtl/pd_out_reg.sv
module pd_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic nxt_flag,
  output logic flag_q
);

  always_ff @(posedge clk) begin
    if (rst)       flag_q <= 1'b0;
    else if (step) flag_q <= nxt_flag;
  end

  // R1: flag cleared by reset
  a_r1_flag_clear: assert property (@(posedge clk) rst |=> !flag_q);

  // R6: an enabled step always drops a raised flag
  a_r6_one_step: assert property (@(posedge clk) disable iff (rst)
    (step && flag_q) |=> !flag_q);

endmodule

// File: rtl/pd_serial_det.sv
module pd_serial_det
  import pd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic x_in,
  output logic z_out
);

  pd_state_e cur_st;
  pd_state_e nxt_st;
  logic      nxt_flag;
  logic      step;

  // Named event: an edge that actually advances the machine.
  assign step = en & ~rst;

  pd_next u_next (
    .cur_st  (cur_st),
    .bit_in  (x_in),
    .nxt_st  (nxt_st),
    .nxt_flag(nxt_flag)
  );

  pd_state_reg u_state (
    .clk   (clk),
    .rst   (rst),
    .step  (en),
    .nxt_st(nxt_st),
    .cur_st(cur_st)
  );

  pd_out_reg u_out (
    .clk     (clk),
    .rst     (rst),
    .step    (en),
    .nxt_flag(nxt_flag),
    .flag_q  (z_out)
  );

  // R3: completing 0 after 0,1 raises the flag next cycle
  a_r3_complete: assert property (@(posedge clk) disable iff (rst)
    (step && cur_st == PD_SAW01 && !x_in) |=> z_out);

  // R4: a 1 right after a match keeps the "01" partial match
  a_r4_overlap: assert property (@(posedge clk) disable iff (rst)
    (step && cur_st == PD_HIT && x_in) |=> (cur_st == PD_SAW01));

  // R6: flag register and state register agree (Moore output)
  a_r6_moore: assert property (@(posedge clk) disable iff (rst)
    z_out == (cur_st == PD_HIT));

  // R7: flag held on edges without a step
  a_r7_hold_flag: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(z_out));

endmodule

// File: tb/pd_serial_det_tb_top.sv
`timescale 1ns/1ps
module pd_serial_det_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic x_in = 1'b0;
  logic z_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [2:0] hist = 3'b111;   // last three accepted bits, newest in [0]

  always #2.5 clk = ~clk;

  pd_serial_det dut_i (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .x_in (x_in),
    .z_out(z_out)
  );

  task automatic check(input string tag, input logic exp);
    n_checks++;
    if (z_out !== exp) begin
      n_fail++;
      $display("FAIL %s: z_out=%b expected=%b at %0t", tag, z_out, exp, $time);
    end
  endtask

  // One clock: drive at negedge, model at posedge, check at next negedge.
  task automatic cyc(input string tag, input logic r, input logic e, input logic b);
    rst = r; en = e; x_in = b;
    @(posedge clk);
    if (r)      hist = 3'b111;
    else if (e) hist = {hist[1:0], b};
    @(negedge clk);
    check(tag, hist == 3'b010);
  endtask

  task automatic feed(input string tag, input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) cyc(tag, 1'b0, 1'b1, bits[i]);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) cyc("R1", 1'b1, i[0], i[1]);
    check("R1", 1'b0);
  endtask

  task automatic t_basic;
    feed("R3", 16'b010, 3);
    feed("R3", 16'b11, 2);
  endtask

  task automatic t_overlap;
    feed("R4", 16'b01010, 5);
    feed("R4", 16'b00, 2);
    feed("R4", 16'b1010, 4);
  endtask

  task automatic t_nomatch;
    feed("R5", 16'b1111, 4);
    feed("R5", 16'b0000, 4);
    feed("R5", 16'b0110110, 7);
  endtask

  task automatic t_moore_hold;
    feed("R6", 16'b1010, 4);        // ends in match state
    for (int i = 0; i < 4; i++) cyc("R7", 1'b0, 1'b0, i[0]);
    cyc("R6", 1'b0, 1'b1, 1'b0);    // flag drops after one step
    cyc("R7", 1'b0, 1'b0, 1'b1);
    cyc("R7", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset_priority;
    feed("R2", 16'b01, 2);
    cyc("R2", 1'b1, 1'b0, 1'b0);    // reset with enable low, completing bit present
    cyc("R2", 1'b0, 1'b1, 1'b0);    // must not complete a pattern
    cyc("R2", 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_third_rate;
    logic [7:0] s = 8'b01010011;
    for (int i = 7; i >= 0; i--) begin
      cyc("R8", 1'b0, 1'b1, s[i]);
      cyc("R8", 1'b0, 1'b0, ~s[i]);
      cyc("R8", 1'b0, 1'b0, s[i]);
    end
  endtask

  task automatic t_random;
    for (int i = 0; i < 3000; i++)
      cyc("R3", ($urandom_range(0, 199) == 0), ($urandom_range(0, 2) != 0), $urandom_range(0, 1));
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    cyc("R1", 1'b0, 1'b0, 1'b0);
    t_basic();
    t_overlap();
    t_nomatch();
    t_moore_hold();
    t_reset_priority();
    t_third_rate();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule